// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a cycle-accurate model of a synchronous static RAM built for full bus use. Address, control and write data are registered on the rising clock edge. Writes are late: the data for a write command arrives two enabled cycles after the command. Reads have a matching two-cycle latency. Because of this, read and write commands can alternate on consecutive cycles with no idle cycle between them. A small byte-lane memory holds the data. It is written so that it maps onto block RAM with per-lane write enables.

A command is either loaded with a fresh address or continued as a four-beat burst. A burst sequencer produces the following addresses in interleaved or linear order. Three chip enables select the device. An active-low clock enable freezes the whole pipeline. A sleep input shuts the device down after a two-cycle delay and brings it back after the same delay. When a read hits an address whose write data is still in flight, the pending bytes are forwarded per lane, so the read returns the newest value.

Top module: `nowait_sram`

## Requirements
- R1: While `clk_en_n` is 1, every synchronous input is ignored and all pipeline state and outputs hold. A read issued earlier completes only after two further enabled edges, and write commands given while suspended never reach memory.
- R2: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load (`load_n`=0) with any other combination is a deselect. A deselect produces no output data and no memory write, even when `wr_n`=0.
- R3: On a load (`load_n`=0), `addr` and a new command are taken. With `load_n`=1, the previous command continues at the next burst address. Continuing a deselect, including right after reset, stays a deselect.
- R4: A burst covers four beats; `addr[1:0]` is the start and the upper address bits stay fixed. With `burst_mode`=1, beat k uses low bits start XOR k. With `burst_mode`=0, beat k uses (start + k) mod 4.
- R5: `wr_n`=0 selects a write and `wr_n`=1 a read. `lane_wr_n[i]`=0 writes bits [9i+8:9i]. A write with all four `lane_wr_n` bits at 1 leaves memory unchanged.
- R6: Data for a read command registered at enabled edge t is on `rdata`, with `rd_valid`=1, right after enabled edge t+2. For a write command registered at edge t, `wdata` is sampled at enabled edge t+2.
- R7: Read and write commands may alternate on every cycle with no wait cycle. Every read returns data and every write lands.
- R8: A read whose address matches a write issued one cycle earlier, with that write's data not yet in memory, returns the new bytes in the written lanes and the old bytes in the other lanes.
- R9: `rd_valid` is 1 only when read data is present, `oe_n`=0 and the device is awake. `oe_n` acts in the same cycle. Whenever `rd_valid`=0, `rdata` is 0.
- R10: After `sleep` rises, two more edges sample inputs; then inputs are ignored and `rd_valid` stays 0. After `sleep` falls, inputs are ignored for two more edges and sampled from the third. Memory and pipeline contents survive the sleep.
- R11: A synchronous `rst` clears all pipeline valid bits and sets `rd_valid`=0 and `rdata`=0. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; 1 suspends the block |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| load_n | input | 1 | 0 loads a new address and command, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read |
| lane_wr_n | input | LANES | Active-low byte lane write enables |
| oe_n | input | 1 | Active-low output enable |
| sleep | input | 1 | Sleep request |
| burst_mode | input | 1 | 1 interleaved, 0 linear burst order |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after the write command |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rd_valid | output | 1 | Output driven flag; 0 means high impedance |

## Verification
A wrong valid bit in the read pipeline shows at the ports exactly two enabled edges after the command, as a missing or spurious `rd_valid`. A wrong burst counter or sequence gives wrong data on the next continued beat. A broken forwarding path shows only when a read follows a write to the same address by one cycle. Bad lane merging appears as single wrong 9-bit fields. Suspend and sleep faults appear as outputs that move, or pending commands that complete, one edge early.

// File: rtl/nws_pkg.sv
package nws_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2
  } cmd_e;
endpackage

// File: rtl/nws_burst.sv
module nws_burst #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int BW = 2;

  logic [ADDR_W-1:0] base_q;
  logic [BW-1:0]     cnt_q;
  logic [BW-1:0]     cnt_nxt;
  logic [BW-1:0]     low;

  assign cnt_nxt  = cnt_q + 1'b1;
  assign low      = interleave ? (base_q[BW-1:0] ^ cnt_nxt) : (base_q[BW-1:0] + cnt_nxt);
  assign eff_addr = load ? addr_in : {base_q[ADDR_W-1:BW], low};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  // R4: each continued beat moves the burst one position on
  a_r4_beat_advances: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));
endmodule

// File: rtl/nws_array.sv
module nws_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_q,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] q_r;

    always_ff @(posedge clk) begin
      if (wr_lane[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
      if (rd_en) q_r <= bank[rd_addr];
    end

    assign rd_q[g*LANE_W +: LANE_W] = q_r;
  end
endmodule

// File: rtl/nws_wpipe.sv
module nws_wpipe #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              in_v,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_lane,
  output logic              c_v,
  output logic [ADDR_W-1:0] c_addr,
  output logic [LANES-1:0]  c_lane
);
  logic              s1_v;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      c_v  <= 1'b0;
    end else if (step) begin
      s1_v <= in_v;
      c_v  <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      s1_addr <= in_addr;
      s1_lane <= in_lane;
      c_addr  <= s1_addr;
      c_lane  <= s1_lane;
    end
  end

  // R1: a suspended edge leaves the pending write untouched
  a_r1_wpipe_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(c_v) && $stable(c_addr) && $stable(c_lane)));
endmodule

// File: rtl/nowait_sram.sv
module nowait_sram
  import nws_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    load_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic                    burst_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rd_valid
);
  localparam int DATA_W = LANES * LANE_W;

  // sleep delay line runs on every edge
  logic sl1_q, sl2_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sl1_q <= 1'b0;
      sl2_q <= 1'b0;
    end else begin
      sl1_q <= sleep;
      sl2_q <= sl1_q;
    end
  end

  logic step, chip_sel;
  assign step     = !clk_en_n && !sl2_q;
  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

  cmd_e cmd_q, cur_cmd;
  always_comb begin
    if (!load_n) cur_cmd = chip_sel ? (wr_n ? CMD_RD : CMD_WR) : CMD_IDLE;
    else         cur_cmd = cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst)       cmd_q <= CMD_IDLE;
    else if (step) cmd_q <= cur_cmd;
  end

  logic [ADDR_W-1:0] eff_addr;
  nws_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .step(step), .load(!load_n),
    .interleave(burst_mode), .addr_in(addr), .eff_addr(eff_addr)
  );

  logic              c_v;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_lane;
  nws_wpipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wpipe (
    .clk(clk), .rst(rst), .step(step),
    .in_v(cur_cmd == CMD_WR), .in_addr(eff_addr), .in_lane(~lane_wr_n),
    .c_v(c_v), .c_addr(c_addr), .c_lane(c_lane)
  );

  // read pipeline
  logic              r1_v, r2_v, out_vld_q;
  logic [ADDR_W-1:0] r1_addr;
  logic [LANES-1:0]  fwd_mask_q;
  logic [DATA_W-1:0] fwd_data_q, rd_q, merged, dout_q;

  nws_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rd_en(step), .rd_addr(r1_addr), .rd_q(rd_q),
    .wr_lane((step && c_v) ? c_lane : '0), .wr_addr(c_addr), .wr_data(wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_v       <= 1'b0;
      r2_v       <= 1'b0;
      out_vld_q  <= 1'b0;
      fwd_mask_q <= '0;
      dout_q     <= '0;
    end else if (step) begin
      r1_v       <= (cur_cmd == CMD_RD);
      r2_v       <= r1_v;
      fwd_mask_q <= (c_v && (c_addr == r1_addr)) ? c_lane : '0;
      out_vld_q  <= r2_v;
      dout_q     <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (step) begin
      r1_addr    <= eff_addr;
      fwd_data_q <= wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = fwd_mask_q[g] ? fwd_data_q[g*LANE_W +: LANE_W]
                                                      : rd_q[g*LANE_W +: LANE_W];
  end

  assign rd_valid = out_vld_q && !oe_n && !sl2_q;
  assign rdata    = rd_valid ? dout_q : '0;

  // R1: suspended edges freeze the output stage
  a_r1_out_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(dout_q) && $stable(out_vld_q)));
  // R2: a load without full selection starts no read
  a_r2_deselect_no_read: assert property (@(posedge clk) disable iff (rst)
    (step && !load_n && !chip_sel) |=> !r1_v);
  // R9: data is driven only with the output enable low
  a_r9_drive_needs_oe: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !oe_n);
  // R10: asleep means nothing driven
  a_r10_quiet_asleep: assert property (@(posedge clk) disable iff (rst)
    sl2_q |-> !rd_valid);
  // R11: first cycle after reset drives nothing
  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && rdata == '0));
endmodule

// File: tb/sim_nowait_sram.sv
module sim_nowait_sram;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, clk_en_n, sel_a_n, sel_b, sel_c_n, load_n, wr_n, oe_n, sleep, burst_mode;
  logic [NL-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rd_valid;

  nowait_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .oe_n(oe_n), .sleep(sleep), .burst_mode(burst_mode), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid)
  );

  typedef struct packed {
    logic          ld_n;
    logic          wr_n;
    logic [2:0]    sel;   // {sel_a_n, sel_b, sel_c_n}
    logic [NL-1:0] ln;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    logic          ev;
    logic [DW-1:0] ed;
  } vec_t;

  function automatic vec_t mk(logic ld, logic w, logic [2:0] s, logic [NL-1:0] l,
                              logic [AW-1:0] ad, logic [DW-1:0] d, logic v, logic [DW-1:0] e);
    vec_t t;
    t.ld_n = ld; t.wr_n = w; t.sel = s; t.ln = l; t.a = ad; t.wd = d; t.ev = v; t.ed = e;
    return t;
  endfunction

  function automatic logic [DW-1:0] mrg(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NL-1:0] ln);
    logic [DW-1:0] r;
    for (int i = 0; i < NL; i++)
      r[i*LW +: LW] = ln[i] ? old[i*LW +: LW] : nw[i*LW +: LW];
    return r;
  endfunction

  localparam logic [DW-1:0] D10 = 36'h9_1234_5610;
  localparam logic [DW-1:0] D11 = 36'h8_ABCD_EF11;
  localparam logic [DW-1:0] D12 = 36'h7_0F0F_0F12;
  localparam logic [DW-1:0] D13 = 36'h6_5555_AA13;
  localparam logic [DW-1:0] FF  = 36'hF_FFFF_FFFF;
  localparam logic [DW-1:0] M13 = mrg(D13, FF, 4'b1010);
  localparam logic [2:0]    OK  = 3'b010;

  // each row: inputs for one edge, expected output right after that edge
  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    mk(0,0,OK,4'h0,8'h10,'0,0,'0),        // W 10
    mk(0,0,OK,4'h0,8'h11,'0,0,'0),        // W 11
    mk(0,1,OK,4'hF,8'h10,D10,0,'0),       // R 10, data for W 10
    mk(0,0,OK,4'h0,8'h12,D11,0,'0),       // W 12, data for W 11
    mk(0,1,OK,4'hF,8'h12,'0,1,D10),       // R 12 right after W 12 (forward)
    mk(0,1,OK,4'hF,8'h11,D12,0,'0),       // R 11, data for W 12
    mk(0,0,OK,4'h0,8'h13,'0,1,D12),       // W 13
    mk(0,1,OK,4'hF,8'h13,'0,1,D11),       // R 13 right after W 13
    mk(0,0,OK,4'b1010,8'h13,D13,0,'0),    // partial W 13, data for W 13
    mk(0,1,OK,4'hF,8'h13,'0,1,D13),       // R 13 right after partial write
    mk(0,1,3'b000,4'hF,8'h10,FF,0,'0),    // deselect, data for partial W 13
    mk(1,1,OK,4'hF,8'h00,'0,1,M13),       // continue deselect
    mk(0,1,OK,4'hF,8'h10,'0,0,'0),        // R 10
    mk(0,0,OK,4'hF,8'h10,'0,0,'0),        // aborted W 10
    mk(0,1,OK,4'hF,8'h10,'0,1,D10),       // R 10 right after abort
    mk(0,0,3'b011,4'h0,8'h12,'0,0,'0),    // write under deselect; zero data for abort
    mk(0,1,3'b110,4'hF,8'h12,'0,1,D10),   // deselect
    mk(0,1,OK,4'hF,8'h11,'0,0,'0),        // R 11 burst start; zeros would land if deselect wrote
    mk(1,1,OK,4'hF,8'h00,'0,0,'0),        // beat 1
    mk(1,1,OK,4'hF,8'h00,'0,1,D11),       // beat 2
    mk(1,1,OK,4'hF,8'h00,'0,1,D10),       // beat 3
    mk(0,1,3'b000,4'hF,8'h00,'0,1,M13),   // deselect
    mk(1,1,OK,4'hF,8'h00,'0,1,D12),       // continue deselect
    mk(1,1,OK,4'hF,8'h00,'0,0,'0)
  };

  function automatic string tag(int i);
    if (i < 10)      return "R6 R7 R8";
    else if (i < 12) return "R2 R3";
    else if (i < 17) return "R5";
    else             return "R4";
  endfunction

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic ev, input logic [DW-1:0] ed);
    logic [DW-1:0] e;
    e = ev ? ed : '0;
    chk((rd_valid === ev) && (rdata === e), req, {rd_valid, rdata}, {ev, e});
  endtask

  task automatic drv(input logic ld, input logic w, input logic [2:0] s,
                     input logic [NL-1:0] l, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    load_n = ld; wr_n = w; {sel_a_n, sel_b, sel_c_n} = s; lane_wr_n = l; addr = ad; wdata = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] ad); drv(0, 1, OK, 4'hF, ad, '0); endtask
  task automatic des(); drv(0, 1, 3'b000, 4'hF, '0, '0); endtask
  task automatic cont(); drv(1, 1, OK, 4'hF, '0, '0); endtask

  initial begin
    repeat (3000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; clk_en_n = 0; oe_n = 0; sleep = 0; burst_mode = 1;
    des();
    tick(); tick();
    chk_out("R11 reset state", 0, '0);
    rst = 0;

    // table walk, interleaved burst order
    for (int i = 0; i < NV; i++) begin
      drv(TBL[i].ld_n, TBL[i].wr_n, TBL[i].sel, TBL[i].ln, TBL[i].a, TBL[i].wd);
      tick();
      chk_out($sformatf("%s row %0d", tag(i), i), TBL[i].ev, TBL[i].ed);
    end

    // R1: suspend
    rd(8'h12); tick();
    chk_out("R1 before suspend", 0, '0);
    clk_en_n = 1; drv(0, 0, OK, 4'h0, 8'h12, '0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_out("R1 suspended edge", 0, '0);
    end
    clk_en_n = 0; des(); tick();
    chk_out("R1 first enabled edge", 0, '0);
    tick();
    chk_out("R1 read completes after suspend", 1, D12);

    // R9: output enable acts at once
    clk_en_n = 1;
    oe_n = 1; #1;
    chk_out("R9 oe high", 0, '0);
    oe_n = 0; #1;
    chk_out("R9 oe low again", 1, D12);
    clk_en_n = 0;

    // R4: linear burst from 0x11
    burst_mode = 0;
    rd(8'h11); tick();
    cont(); tick();
    cont(); tick(); chk_out("R4 linear beat 0", 1, D11);
    cont(); tick(); chk_out("R4 linear beat 1", 1, D12);
    des();  tick(); chk_out("R4 linear beat 2", 1, M13);
    des();  tick(); chk_out("R4 linear wrap", 1, D10);
    tick();         chk_out("R3 idle after burst", 0, '0);
    burst_mode = 1;

    // R10: sleep entry and exit
    sleep = 1; rd(8'h10); tick();
    rd(8'h11); tick();
    chk_out("R10 asleep after two edges", 0, '0);
    drv(0, 0, OK, 4'h0, 8'h10, FF);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_out("R10 asleep", 0, '0);
    end
    sleep = 0;
    tick(); chk_out("R10 wake edge 1", 0, '0);
    tick(); chk_out("R10 wake edge 2", 0, '0);
    des();
    tick(); chk_out("R10 held read 0x10", 1, D10);
    tick(); chk_out("R10 held read 0x11", 1, D11);
    rd(8'h10); tick();
    des(); tick();
    tick(); chk_out("R10 ignored write left 0x10", 1, D10);

    // R11: reset mid-flight
    rd(8'h11); tick();
    rst = 1; tick();
    chk_out("R11 reset clears output", 0, '0);
    rst = 0; des();
    tick(); chk_out("R11 no stale read 1", 0, '0);
    tick(); chk_out("R11 no stale read 2", 0, '0);
    rd(8'h13); tick();
    des(); tick();
    tick(); chk_out("R11 memory kept", 1, M13);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule